// File: doc/BRIEF.md
# Command Slot Round-Robin Issue Selector

This block chooses which pending command slot a storage host port sends to its downstream engine next. It watches a 32-bit vector of slots that hold outstanding commands. Starting from a priority slot, it scans upward and wraps past the top. The first set bit it finds is offered as the next slot to issue, together with a valid flag. When the engine accepts the offer, three things happen: the slot number is kept in a readable current-slot register, a one-hot completion mask for that slot is driven for one cycle so that the owner of the pending vector can clear the bit, and the priority moves to the slot just above the one issued.

The port is controlled by a start bit. When start goes high, the first issue favours slot 0. Every later issue favours the current slot plus one, wrapping modulo the slot count. When start is cleared, the current-slot register is forced to 0 and issuing stops. A running flag follows the start bit with one cycle of lag and shows when the command engine is active.

Top module: `cmd_slot_arbiter`

## Requirements
- R1: While rst_ni is low, cur_slot_o is 0, running_o is 0, valid_o is 0 and done_mask_o is 0.
- R2: running_o equals the value start_i had at the previous rising clock edge. It rises one cycle after start is set and falls one cycle after start is cleared.
- R3: valid_o is 1 only when start_i is 1, running_o is 1 and at least one pend_i bit is set. A slot is never offered in the cycle in which start_i rises.
- R4: On the first issue after start_i rises, the priority slot is 0, so slot_o is the lowest-index set bit of pend_i.
- R5: After an accepted issue, the priority slot is cur_slot_o + 1. With cur_slot_o = 0 and pend_i = 0x3, slot_o is 1.
- R6: The priority wraps modulo 32. With cur_slot_o = 31, the priority slot is 0. A scan that finds no set bit at or above the priority slot continues from slot 0.
- R7: On a clock edge where valid_o and accept_i are both 1, cur_slot_o takes the value of slot_o and shows it from the next cycle.
- R8: In the cycle after an accepted issue, done_mask_o has exactly bit slot_o set. In every other cycle, done_mask_o is 0.
- R9: When accept_i is 0, an offered slot is not issued: cur_slot_o holds and done_mask_o stays 0.
- R10: When pend_i is 0, valid_o is 0 and cur_slot_o holds.
- R11: One cycle after start_i is cleared, cur_slot_o is 0. When start_i is set again, the first issue again favours slot 0 rather than cur_slot_o + 1 (for pend_i = 0x3 the result is slot 0).
- R12: While valid_o is 1, slot_o is the first set bit of pend_i found by scanning upward from the priority slot with wrap. For example, priority slot 2 with pend_i = 0x101 gives slot 8, and priority slot 9 with pend_i = 0x80000100 gives slot 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Port start/enable bit |
| pend_i | input | 32 | Pending command slots, bit n = slot n |
| accept_i | input | 1 | Downstream engine accepts the offered slot |
| slot_o | output | 5 | Offered slot index |
| valid_o | output | 1 | slot_o is a real offer |
| cur_slot_o | output | 5 | Current-slot register, software-readable |
| running_o | output | 1 | Command engine running flag |
| done_mask_o | output | 32 | One-hot mask of the slot issued on the previous edge |

## Verification
slot_o and valid_o are combinational from pend_i and the registered state, so they are due in the same cycle as the stimulus. cur_slot_o, running_o and done_mask_o are due one edge after the cause. The bench drives inputs on the falling edge. It checks slot_o and valid_o one time unit later, then checks the registered outputs one time unit after the next rising edge. A table of pending vectors walks the priority pointer through wrap, skip and no-accept cases while start is held high. Directed steps then cover reset, the start edge, the stop clear and the return of slot-0 priority on restart.

// File: rtl/cmd_slot_pkg.sv
package cmd_slot_pkg;
  localparam int unsigned SLOTS_DEFAULT = 32;

  // circular successor of a slot index
  function automatic int unsigned slot_succ(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/slot_rr_picker.sv
module slot_rr_picker #(
  parameter int unsigned N = 32,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] base_i,
  output logic         vld_o,
  output logic [W-1:0] idx_o
);
  logic [N-1:0] rot;
  logic [W-1:0] off;
  logic [W:0]   sum;

  // rotate so that the base slot lands on bit 0
  always_comb begin
    for (int i = 0; i < N; i++) begin
      int j;
      j = i + int'(base_i);
      if (j >= int'(N)) j = j - int'(N);
      rot[i] = req_i[j];
    end
  end

  always_comb begin
    off = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) off = W'(i);
    end
  end

  assign vld_o = |req_i;
  assign sum   = {1'b0, base_i} + {1'b0, off};
  assign idx_o = (sum >= (W+1)'(N)) ? W'(sum - (W+1)'(N)) : sum[W-1:0];

  AST_PICK_IS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> req_i[idx_o]); // R12
endmodule

// File: rtl/slot_ptr_ctrl.sv
module slot_ptr_ctrl #(
  parameter int unsigned N = 32,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         issue_i,
  input  logic [W-1:0] issue_idx_i,
  output logic [W-1:0] cur_o,
  output logic         run_o,
  output logic [W-1:0] base_o
);
  import cmd_slot_pkg::*;

  logic [W-1:0] cur_q;
  logic         run_q;
  logic         first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      run_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      run_q <= start_i;
      if (!start_i) begin
        cur_q   <= '0;
        first_q <= 1'b0;
      end else if (!run_q) begin
        first_q <= 1'b1;
      end else if (issue_i) begin
        cur_q   <= issue_idx_i;
        first_q <= 1'b0;
      end
    end
  end

  assign cur_o  = cur_q;
  assign run_o  = run_q;
  assign base_o = first_q ? '0 : W'(slot_succ(int'(cur_q), N));

  AST_RUN_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> run_o); // R2
  AST_RUN_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !run_o); // R2
  AST_STOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (cur_o == '0)); // R11
  AST_CUR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> (cur_o == $past(issue_idx_i))); // R7
  AST_CUR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !issue_i) |=> $stable(cur_o)); // R9
endmodule

// File: rtl/cmd_slot_arbiter.sv
module cmd_slot_arbiter #(
  parameter int unsigned NUM_SLOTS = cmd_slot_pkg::SLOTS_DEFAULT,
  localparam int unsigned IW = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [NUM_SLOTS-1:0] pend_i,
  input  logic                 accept_i,
  output logic [IW-1:0]        slot_o,
  output logic                 valid_o,
  output logic [IW-1:0]        cur_slot_o,
  output logic                 running_o,
  output logic [NUM_SLOTS-1:0] done_mask_o
);
  logic [IW-1:0] base;
  logic          pick_vld;
  logic [IW-1:0] pick_idx;
  logic          issue;

  slot_rr_picker #(.N(NUM_SLOTS)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (pend_i),
    .base_i (base),
    .vld_o  (pick_vld),
    .idx_o  (pick_idx)
  );

  slot_ptr_ctrl #(.N(NUM_SLOTS)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .issue_i     (issue),
    .issue_idx_i (pick_idx),
    .cur_o       (cur_slot_o),
    .run_o       (running_o),
    .base_o      (base)
  );

  assign valid_o = start_i && running_o && pick_vld;
  assign slot_o  = pick_idx;
  assign issue   = valid_o && accept_i;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) done_mask_o[g] <= 1'b0;
      else         done_mask_o[g] <= issue && (pick_idx == IW'(g));
    end
  end

  AST_NO_ISSUE_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |-> !valid_o); // R3
  AST_MASK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_mask_o)); // R8
  AST_MASK_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_mask_o) |-> $past(valid_o && accept_i)); // R8
  AST_ISSUE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && accept_i) |=> done_mask_o[$past(slot_o)]); // R8
endmodule

// File: tb/cmd_slot_arbiter_test.sv
module cmd_slot_arbiter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] pend_i = '0;
  logic        accept_i = 1'b0;
  logic [4:0]  slot_o;
  logic        valid_o;
  logic [4:0]  cur_slot_o;
  logic        running_o;
  logic [31:0] done_mask_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  cmd_slot_arbiter uut (
    .clk_i, .rst_ni, .start_i, .pend_i, .accept_i,
    .slot_o, .valid_o, .cur_slot_o, .running_o, .done_mask_o
  );

  always #5 clk_i = ~clk_i;

  localparam int NV = 10;
  // pending, accept, expected valid, expected slot, expected current slot after the edge
  localparam logic [31:0] T_PEND [NV] = '{32'h0, 32'h3, 32'h3, 32'h3, 32'h101,
                                           32'h8000_0100, 32'h8000_0021, 32'h8000_0000,
                                           32'h8000_0000, 32'h0};
  localparam logic        T_ACC  [NV] = '{1, 1, 1, 0, 1, 1, 1, 1, 1, 1};
  localparam logic        T_VAL  [NV] = '{0, 1, 1, 1, 1, 1, 1, 1, 1, 0};
  localparam logic [4:0]  T_SLOT [NV] = '{0, 0, 1, 0, 8, 31, 0, 31, 31, 0};
  localparam logic [4:0]  T_CUR  [NV] = '{0, 0, 1, 1, 8, 31, 0, 31, 31, 31};
  localparam string       T_REQ  [NV] = '{"R10", "R4", "R5", "R9", "R12",
                                           "R12", "R6", "R6", "R6", "R10"};

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk_i);
    chk("R1", "cur", 32'(cur_slot_o), 0);
    chk("R1", "running", 32'(running_o), 0);
    chk("R1", "valid", 32'(valid_o), 0);
    chk("R1", "mask", done_mask_o, 0);
    rst_ni = 1'b1;

    // start low: nothing offered
    @(negedge clk_i);
    pend_i = 32'h3;
    accept_i = 1'b1;
    #1 chk("R3", "valid stopped", 32'(valid_o), 0);

    // start rises: still no offer in that cycle
    @(negedge clk_i);
    start_i = 1'b1;
    #1 chk("R3", "valid at start edge", 32'(valid_o), 0);
    @(posedge clk_i); #1;
    chk("R2", "running after start", 32'(running_o), 1);
    chk("R9", "no mask before offer", done_mask_o, 0);

    // table walk with start held high
    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      pend_i = T_PEND[k];
      accept_i = T_ACC[k];
      #1;
      chk(T_REQ[k], "valid", 32'(valid_o), 32'(T_VAL[k]));
      if (T_VAL[k]) chk(T_REQ[k], "slot", 32'(slot_o), 32'(T_SLOT[k]));
      @(posedge clk_i); #1;
      chk("R7", "cur", 32'(cur_slot_o), 32'(T_CUR[k]));
      chk("R8", "mask", done_mask_o,
          (T_VAL[k] && T_ACC[k]) ? (32'h1 << T_SLOT[k]) : 32'h0);
    end

    // mask lasts one cycle only
    @(negedge clk_i);
    pend_i = 32'h0;
    @(posedge clk_i); #1;
    chk("R8", "mask cleared", done_mask_o, 0);

    // stop: cur cleared, running falls, no offers
    @(negedge clk_i);
    start_i = 1'b0;
    pend_i = 32'h3;
    #1 chk("R3", "valid after stop", 32'(valid_o), 0);
    @(posedge clk_i); #1;
    chk("R11", "cur after stop", 32'(cur_slot_o), 0);
    chk("R2", "running after stop", 32'(running_o), 0);

    // restart: slot 0 favoured again, not cur+1
    @(negedge clk_i);
    start_i = 1'b1;
    accept_i = 1'b0;
    @(negedge clk_i);
    #1;
    chk("R11", "restart valid", 32'(valid_o), 1);
    chk("R11", "restart slot", 32'(slot_o), 0);
    accept_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R7", "cur after restart issue", 32'(cur_slot_o), 0);
    chk("R8", "mask restart", done_mask_o, 32'h1);
    @(negedge clk_i); #1;
    chk("R5", "second issue after restart", 32'(slot_o), 1);

    // reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1", "cur in reset", 32'(cur_slot_o), 0);
    chk("R1", "running in reset", 32'(running_o), 0);
    chk("R1", "valid in reset", 32'(valid_o), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule